// File: doc/BRIEF.md
# Display Power-Up Sequencer

This block is a hardware state machine that takes a panel timing controller out of power-down. It sends an ordered series of one-byte register writes to an external frame sender. Each byte carries a 3-bit register address in its upper bits and a 5-bit value in its lower bits. The series is interlocked so that the supply rails, the bias DAC, the common-electrode drive and the signal outputs come up in a fixed order. Fixed settle delays, counted in clock cycles from a cycles-per-millisecond parameter, sit between certain writes.

Partway through the series, a serial DAC writer takes over the output. It toggles the clock and data bits of the power-control register, one write per line level, to load the common-electrode voltage. The phase, DAC and resolution values are chosen from three inputs: a VGA/QVGA mode select, a signed stored phase value and a signed stored common-voltage value. All three are sampled when a request is accepted.

A power-off request starts a 34 ms wait and issues no writes; the rest of the power-down order is not part of this block. The block signals the end of either sequence with a single-cycle `done` pulse. Requests that arrive while the block is busy are dropped.

Top module: `panel_pwrup_seq`

## Requirements
- R1: While reset is held, and in idle after it, `frame_valid` and `done` stay 0.
- R2: Each byte is `frame_data[7:5]` = address and `frame_data[4:0]` = value. A byte is taken in a cycle with `frame_valid` and `frame_ready` both high. While `frame_ready` is low, `frame_valid` and `frame_data` hold.
- R3: The accepted bytes follow a fixed order, written as (address,value) in hex: (6,1F) (3,03) (4,00) (4,04) (3,07) (6,09), then the DAC series, then (3,17) (4,06) (6,01) (3,1F) (4,07) (6,00) (1,phase) (7,00) (0,resolution). That is 102 bytes in all.
- R4: `frame_valid` stays low for exactly 3·CLK_PER_MS cycles after (4,04) is accepted, 2·CLK_PER_MS cycles after (4,06), and 1·CLK_PER_MS cycles after (7,00). After every other accepted byte, `frame_valid` is high again in the very next cycle.
- R5: The DAC series is 87 writes to address 3, each with base value 0x04; bit 0 is the serial clock and bit 1 the serial data. It runs as follows.
  - A start: 0x07, 0x05, 0x04.
  - Bytes 0x9C, 0x00 and the DAC value, sent MSB first. Each bit is three writes (d, d|1, d), with d = 0x04 | bit<<1.
  - After each byte, an acknowledge slot: 0x04, 0x05, 0x04.
  - A stop: 0x04, 0x05, 0x07.
- R6: The DAC value is 125 when the stored common-voltage value is negative, and otherwise its low 8 bits.
- R7: The phase value is 0x13 in QVGA mode. In VGA mode it is 0x01 when the stored phase is negative, and otherwise {phase[3:0],1}.
- R8: The resolution value is 0x01 in QVGA mode (`mode_qvga`=1) and 0x00 in VGA mode.
- R9: `done` is high for exactly one cycle, the cycle after the last byte of a power-up is accepted.
- R10: A power-off request accepted in idle produces no bytes. Its `done` pulse comes 34·CLK_PER_MS+1 cycles after the cycle in which the request was sampled.
- R11: Requests seen while busy have no effect, and mode or parameter changes after acceptance have no effect. When power-on and power-off are requested together in idle, power-on wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_on_req | input | 1 | Start the power-up series (sampled in idle) |
| pwr_off_req | input | 1 | Start the power-off wait (sampled in idle) |
| mode_qvga | input | 1 | 1 = QVGA, 0 = VGA |
| phase_adj | input | 5 | Stored phase value, signed |
| comv_adj | input | COMV_W | Stored common-voltage value, signed |
| frame_ready | input | 1 | Frame sender can take a byte |
| frame_valid | output | 1 | A byte is offered |
| frame_data | output | 8 | Offered byte: address in 7:5, value in 4:0 |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The power-up series is run against the full range of signed phase values in VGA mode and against several in QVGA mode. Common-voltage values cover negative numbers, zero, 125, 255 and the most negative value, so the phase and DAC choices are each separated from a fixed table. Every run is repeated under three ready patterns (always ready, mostly ready, rarely ready). These show that the hold rule and the exact settle gaps do not depend on back-pressure. Power-off runs, and runs that toggle the requests and the mode during a sequence, separate the accepted-request path from the dropped one.

// File: rtl/panel_seq_pkg.sv
// Shared constants and types for the display power-up sequencer.
// Assumes an 8-bit write byte: 3-bit address above a 5-bit value.
package panel_seq_pkg;

    localparam int ADDR_W   = 3;
    localparam int VAL_W    = 5;
    localparam int FRAME_W  = ADDR_W + VAL_W;
    localparam int STEP_W   = 4;
    localparam int NUM_STEP = 15;

    // Register addresses; the panel controller decodes these.
    localparam logic [ADDR_W-1:0] A_RESOL = 3'd0;
    localparam logic [ADDR_W-1:0] A_PHASE = 3'd1;
    localparam logic [ADDR_W-1:0] A_PWR0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_PWR1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_IFCTL = 3'd6;
    localparam logic [ADDR_W-1:0] A_POLAR = 3'd7;

    // Serial DAC constants: base level keeps DAC supply on only.
    localparam logic [VAL_W-1:0] DAC_BASE    = 5'h04;
    localparam logic [7:0]       DAC_CMD0    = 8'h9C;
    localparam logic [7:0]       DAC_CMD1    = 8'h00;
    localparam logic [7:0]       DAC_DEFAULT = 8'd125;

    // What follows a step once its byte is accepted.
    typedef enum logic [2:0] {
        POST_NEXT,
        POST_WAIT_A,
        POST_DAC,
        POST_WAIT_B,
        POST_WAIT_C,
        POST_LAST
    } post_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_DAC,
        ST_WAIT,
        ST_OFF
    } seq_state_t;

    function automatic logic [FRAME_W-1:0] pack_frame(
        input logic [ADDR_W-1:0] a,
        input logic [VAL_W-1:0]  v
    );
        return {a, v};
    endfunction

endpackage

// File: rtl/pwrup_step_rom.sv
// Step table of the power-up series: for a step index, the byte to send
// and the action that follows its acceptance.
// Assumes mode and phase are already latched by the caller.
module pwrup_step_rom
    import panel_seq_pkg::*;
(
    input  logic [STEP_W-1:0]  step,
    input  logic               mode_qvga,
    input  logic [VAL_W-1:0]   phase,
    output logic [FRAME_W-1:0] frame,
    output post_t              post
);

    logic [VAL_W-1:0] phase_val;
    logic [VAL_W-1:0] resol_val;

    // Phase value chosen from the mode and the sign of the stored phase.
    always_comb begin
        if (mode_qvga)      phase_val = 5'h13;
        else if (phase[4])  phase_val = 5'h01;
        else                phase_val = {phase[3:0], 1'b1};
        resol_val = mode_qvga ? 5'h01 : 5'h00;
    end

    // Table lookup of byte and follow-up action.
    always_comb begin
        post  = POST_NEXT;
        frame = pack_frame(A_IFCTL, 5'h1F);
        case (step)
            4'd0:  frame = pack_frame(A_IFCTL, 5'h1F);
            4'd1:  frame = pack_frame(A_PWR0,  5'h03);
            4'd2:  frame = pack_frame(A_PWR1,  5'h00);
            4'd3:  begin frame = pack_frame(A_PWR1, 5'h04); post = POST_WAIT_A; end
            4'd4:  frame = pack_frame(A_PWR0,  5'h07);
            4'd5:  begin frame = pack_frame(A_IFCTL, 5'h09); post = POST_DAC; end
            4'd6:  frame = pack_frame(A_PWR0,  5'h17);
            4'd7:  begin frame = pack_frame(A_PWR1, 5'h06); post = POST_WAIT_B; end
            4'd8:  frame = pack_frame(A_IFCTL, 5'h01);
            4'd9:  frame = pack_frame(A_PWR0,  5'h1F);
            4'd10: frame = pack_frame(A_PWR1,  5'h07);
            4'd11: frame = pack_frame(A_IFCTL, 5'h00);
            4'd12: frame = pack_frame(A_PHASE, phase_val);
            4'd13: begin frame = pack_frame(A_POLAR, 5'h00); post = POST_WAIT_C; end
            4'd14: begin frame = pack_frame(A_RESOL, resol_val); post = POST_LAST; end
            default: begin frame = pack_frame(A_RESOL, resol_val); post = POST_LAST; end
        endcase
    end

endmodule

// File: rtl/dac_serial_writer.sv
// Drives a two-wire serial DAC through the clock (bit 0) and data (bit 1)
// of power register 0: start, three bytes each with an acknowledge slot,
// stop. One write per line level; every write waits for ready.
// Assumes start is only raised while this block is idle.
module dac_serial_writer
    import panel_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [7:0]         value,
    input  logic               ready,
    output logic               valid,
    output logic [FRAME_W-1:0] frame,
    output logic               last_xfer
);

    localparam int LEVELS   = 3;
    localparam int DBITS    = 8;
    localparam int NBYTES   = 3;
    localparam logic [1:0] PH_LAST   = 2'(LEVELS - 1);
    localparam logic [3:0] BIT_ACK   = 4'(DBITS);
    localparam logic [1:0] BYTE_LAST = 2'(NBYTES - 1);

    typedef enum logic [1:0] {W_IDLE, W_START, W_BODY, W_STOP} wseg_t;

    wseg_t      seg;
    logic [1:0] ph;
    logic [3:0] bitn;
    logic [1:0] byten;
    logic [7:0] val_q;
    logic [7:0] cur_byte;
    logic       dout;
    logic [VAL_W-1:0] lvl;
    logic [VAL_W-1:0] payload;
    logic       xfer;

    // Select the byte in flight and the data bit of the current slot.
    always_comb begin
        case (byten)
            2'd0:    cur_byte = DAC_CMD0;
            2'd1:    cur_byte = DAC_CMD1;
            default: cur_byte = val_q;
        endcase
        dout = (bitn < BIT_ACK) ? cur_byte[3'd7 - bitn[2:0]] : 1'b0;
        lvl  = DAC_BASE | {3'b000, dout, 1'b0};
    end

    // Line levels per segment and level index.
    always_comb begin
        case (seg)
            W_START: payload = (ph == 2'd0) ? (DAC_BASE | 5'h03) :
                               (ph == 2'd1) ? (DAC_BASE | 5'h01) : DAC_BASE;
            W_BODY:  payload = (ph == 2'd1) ? (lvl | 5'h01) : lvl;
            W_STOP:  payload = (ph == 2'd0) ? DAC_BASE :
                               (ph == 2'd1) ? (DAC_BASE | 5'h01) : (DAC_BASE | 5'h03);
            default: payload = DAC_BASE;
        endcase
    end

    assign valid     = (seg != W_IDLE);
    assign frame     = pack_frame(A_PWR0, payload);
    assign xfer      = valid && ready;
    assign last_xfer = xfer && (seg == W_STOP) && (ph == PH_LAST);

    // Walk levels, bits, bytes and segments on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg   <= W_IDLE;
            ph    <= 2'd0;
            bitn  <= 4'd0;
            byten <= 2'd0;
            val_q <= 8'd0;
        end else if (seg == W_IDLE) begin
            if (start) begin
                seg   <= W_START;
                ph    <= 2'd0;
                bitn  <= 4'd0;
                byten <= 2'd0;
                val_q <= value;
            end
        end else if (xfer) begin
            if (ph != PH_LAST) begin
                ph <= ph + 2'd1;
            end else begin
                ph <= 2'd0;
                case (seg)
                    W_START: seg <= W_BODY;
                    W_BODY: begin
                        if (bitn == BIT_ACK) begin
                            bitn <= 4'd0;
                            if (byten == BYTE_LAST) seg <= W_STOP;
                            else                    byten <= byten + 2'd1;
                        end else begin
                            bitn <= bitn + 4'd1;
                        end
                    end
                    default: seg <= W_IDLE;
                endcase
            end
        end
    end

    p_slot_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (ph <= PH_LAST) && (bitn <= BIT_ACK) && (byten <= BYTE_LAST));

    p_start_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (seg == W_IDLE));

    p_hold_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid && $stable(frame));

endmodule

// File: rtl/seq_timer.sv
// Settle-delay counter: a start pulse loads a limit; the timer then runs
// for exactly that many cycles, with expire high in the last one.
// Assumes limit >= 1 and start is not raised while running.
module seq_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] limit,
    output logic          running,
    output logic          expire
);

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit_q;

    assign expire = running && (cnt == limit_q - TW'(1));

    // Count from zero up to the latched limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            cnt     <= '0;
            limit_q <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            cnt     <= '0;
            limit_q <= limit;
        end else if (running) begin
            if (expire) running <= 1'b0;
            else        cnt     <= cnt + TW'(1);
        end
    end

    p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < limit_q));

    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> !start);

endmodule

// File: rtl/panel_pwrup_seq.sv
// Power-up sequencer for a panel timing controller. It walks the step
// table, hands the output to the serial DAC writer at the DAC step, and
// inserts settle delays. A power-off request runs the long pre-off wait.
// Assumes one byte at a time to a frame sender with a ready handshake.
module panel_pwrup_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_PER_MS  = 1000,
    parameter int COMV_W      = 9,
    parameter int WAIT_A_MS   = 3,
    parameter int WAIT_B_MS   = 2,
    parameter int WAIT_C_MS   = 1,
    parameter int OFF_WAIT_MS = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pwr_on_req,
    input  logic                     pwr_off_req,
    input  logic                     mode_qvga,
    input  logic signed [4:0]        phase_adj,
    input  logic signed [COMV_W-1:0] comv_adj,
    input  logic                     frame_ready,
    output logic                     frame_valid,
    output logic [7:0]               frame_data,
    output logic                     done
);

    localparam int CYC_A   = WAIT_A_MS * CLK_PER_MS;
    localparam int CYC_B   = WAIT_B_MS * CLK_PER_MS;
    localparam int CYC_C   = WAIT_C_MS * CLK_PER_MS;
    localparam int CYC_OFF = OFF_WAIT_MS * CLK_PER_MS;
    localparam int CYC_MAX = (CYC_OFF > CYC_A) ? CYC_OFF : CYC_A;
    localparam int TW      = $clog2(CYC_MAX + 1);
    localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NUM_STEP - 1);

    seq_state_t         state;
    logic [STEP_W-1:0]  step_q;
    logic               mode_q;
    logic [VAL_W-1:0]   phase_q;
    logic [7:0]         dacval_q;
    logic               done_q;

    logic [FRAME_W-1:0] rom_frame;
    post_t              post;
    logic               dac_valid;
    logic [FRAME_W-1:0] dac_frame;
    logic               dac_last;
    logic               dac_start;
    logic               hs_main;
    logic               tmr_start;
    logic [TW-1:0]      tmr_limit;
    logic               tmr_running;
    logic               tmr_expire;
    logic               off_go;
    logic [7:0]         dac_pick;

    pwrup_step_rom u_rom (
        .step      (step_q),
        .mode_qvga (mode_q),
        .phase     (phase_q),
        .frame     (rom_frame),
        .post      (post)
    );

    dac_serial_writer u_dac (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dac_start),
        .value     (dacval_q),
        .ready     (frame_ready),
        .valid     (dac_valid),
        .frame     (dac_frame),
        .last_xfer (dac_last)
    );

    seq_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .limit   (tmr_limit),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    // DAC value: default when the stored value is negative.
    assign dac_pick = comv_adj[COMV_W-1] ? DAC_DEFAULT : comv_adj[7:0];

    // Output mux and handshake decode.
    always_comb begin
        hs_main     = (state == ST_SEND) && frame_ready;
        frame_valid = (state == ST_SEND) || dac_valid;
        frame_data  = dac_valid ? dac_frame : rom_frame;
        dac_start   = hs_main && (post == POST_DAC);
        off_go      = (state == ST_IDLE) && !pwr_on_req && pwr_off_req;
    end

    // Timer start and limit selection.
    always_comb begin
        tmr_start = off_go;
        tmr_limit = TW'(CYC_OFF);
        if (hs_main) begin
            case (post)
                POST_WAIT_A: begin tmr_start = 1'b1; tmr_limit = TW'(CYC_A); end
                POST_WAIT_B: begin tmr_start = 1'b1; tmr_limit = TW'(CYC_B); end
                POST_WAIT_C: begin tmr_start = 1'b1; tmr_limit = TW'(CYC_C); end
                default: ;
            endcase
        end
    end

    // Main sequencing state, step index, latched inputs and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            step_q   <= '0;
            mode_q   <= 1'b0;
            phase_q  <= '0;
            dacval_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (pwr_on_req) begin
                        state    <= ST_SEND;
                        step_q   <= '0;
                        mode_q   <= mode_qvga;
                        phase_q  <= phase_adj;
                        dacval_q <= dac_pick;
                    end else if (pwr_off_req) begin
                        state <= ST_OFF;
                    end
                end
                ST_SEND: begin
                    if (frame_ready) begin
                        case (post)
                            POST_NEXT:   step_q <= step_q + STEP_W'(1);
                            POST_DAC:    state  <= ST_DAC;
                            POST_LAST: begin
                                state  <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                            default:     state  <= ST_WAIT;
                        endcase
                    end
                end
                ST_WAIT: begin
                    if (tmr_expire) begin
                        state  <= ST_SEND;
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_DAC: begin
                    if (dac_last) begin
                        state  <= ST_SEND;
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_OFF: begin
                    if (tmr_expire) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign done = done_q;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !frame_valid);

    p_hold_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_ready) |=> frame_valid && $stable(frame_data));

    p_known_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_data[7:5] != 3'd2) && (frame_data[7:5] != 3'd5));

    p_quiet_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_running |-> !frame_valid);

    p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND) |-> (step_q <= STEP_LAST));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_one_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dac_valid |-> (state == ST_DAC));

endmodule

// File: tb/tb_panel_pwrup_seq.sv
// Self-checking bench: sweeps phase, common-voltage and mode values under
// several ready patterns; expected bytes and gaps are computed here.
module tb_panel_pwrup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 10;
    localparam int NFR        = 102;
    localparam int WD_LIMIT   = 150000;

    logic              clk;
    logic              rst_n;
    logic              pwr_on_req;
    logic              pwr_off_req;
    logic              mode_qvga;
    logic signed [4:0] phase_adj;
    logic signed [8:0] comv_adj;
    logic              frame_ready;
    logic              frame_valid;
    logic [7:0]        frame_data;
    logic              done;

    panel_pwrup_seq #(.CLK_PER_MS(CPM)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_on_req  (pwr_on_req),
        .pwr_off_req (pwr_off_req),
        .mode_qvga   (mode_qvga),
        .phase_adj   (phase_adj),
        .comv_adj    (comv_adj),
        .frame_ready (frame_ready),
        .frame_valid (frame_valid),
        .frame_data  (frame_data),
        .done        (done)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int rdy_mode = 0;
    logic [15:0] lfsr;

    logic [7:0] cap_q[$];
    int         hs_q[$];
    int         rise_q[$];
    int         ndone    = 0;
    int         done_cyc = 0;
    bit         in_frame = 0;
    bit         stall_prev = 0;
    logic [7:0] stall_data;
    bit         in_reset = 1;

    logic [7:0] exp_f[NFR];
    int         exp_gap[NFR];

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Ready pattern driver.
    initial begin
        lfsr = 16'hACE1;
        frame_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       frame_ready = 1'b1;
                1:       frame_ready = lfsr[0] | lfsr[3];
                default: frame_ready = lfsr[0] & lfsr[5];
            endcase
        end
    end

    // Output monitor, sampling between edges.
    initial begin
        forever begin
            @(negedge clk);
            if (in_reset) begin
                chk(!frame_valid && !done, "R1", "reset outputs", {frame_valid, done}, 0);
            end else begin
                if (stall_prev)
                    chk(frame_valid && frame_data == stall_data, "R2", "hold under stall",
                        {frame_valid, frame_data}, {1'b1, stall_data});
                if (frame_valid && !in_frame) begin
                    rise_q.push_back(cyc);
                    in_frame = 1;
                end
                stall_prev = frame_valid && !frame_ready;
                stall_data = frame_data;
                if (frame_valid && frame_ready) begin
                    cap_q.push_back(frame_data);
                    hs_q.push_back(cyc);
                    in_frame = 0;
                end
                if (done) begin
                    ndone++;
                    done_cyc = cyc;
                end
            end
        end
    end

    // Watchdog: counts as a failed check.
    initial begin
        wait (cyc > WD_LIMIT);
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    // Expected byte list and gaps from the requirements.
    task automatic build_exp(input bit qv, input logic signed [4:0] ph, input int cv);
        int k = 0;
        logic [7:0] v;
        logic [7:0] bytes3[3];
        logic [4:0] phv;
        logic [4:0] d;
        for (int i = 0; i < NFR; i++) exp_gap[i] = 0;
        v = (cv < 0) ? 8'd125 : 8'(cv);
        if (qv)          phv = 5'h13;
        else if (ph < 0) phv = 5'h01;
        else             phv = 5'(ph * 2 + 1);
        bytes3[0] = 8'h9C; bytes3[1] = 8'h00; bytes3[2] = v;
        exp_f[k++] = {3'd6, 5'h1F};
        exp_f[k++] = {3'd3, 5'h03};
        exp_f[k++] = {3'd4, 5'h00};
        exp_f[k++] = {3'd4, 5'h04};
        exp_gap[k] = 3 * CPM;
        exp_f[k++] = {3'd3, 5'h07};
        exp_f[k++] = {3'd6, 5'h09};
        exp_f[k++] = {3'd3, 5'h07};
        exp_f[k++] = {3'd3, 5'h05};
        exp_f[k++] = {3'd3, 5'h04};
        for (int b = 0; b < 3; b++) begin
            for (int bit_i = 7; bit_i >= 0; bit_i--) begin
                d = 5'h04 + (bytes3[b][bit_i] ? 5'h02 : 5'h00);
                exp_f[k++] = {3'd3, d};
                exp_f[k++] = {3'd3, d + 5'h01};
                exp_f[k++] = {3'd3, d};
            end
            exp_f[k++] = {3'd3, 5'h04};
            exp_f[k++] = {3'd3, 5'h05};
            exp_f[k++] = {3'd3, 5'h04};
        end
        exp_f[k++] = {3'd3, 5'h04};
        exp_f[k++] = {3'd3, 5'h05};
        exp_f[k++] = {3'd3, 5'h07};
        exp_f[k++] = {3'd3, 5'h17};
        exp_f[k++] = {3'd4, 5'h06};
        exp_gap[k] = 2 * CPM;
        exp_f[k++] = {3'd6, 5'h01};
        exp_f[k++] = {3'd3, 5'h1F};
        exp_f[k++] = {3'd4, 5'h07};
        exp_f[k++] = {3'd6, 5'h00};
        exp_f[k++] = {3'd1, phv};
        exp_f[k++] = {3'd7, 5'h00};
        exp_gap[k] = CPM;
        exp_f[k++] = {3'd0, qv ? 5'h01 : 5'h00};
    endtask

    task automatic wait_done(input int d0, input int limit);
        int g = 0;
        while (ndone == d0 && g < limit) begin
            @(posedge clk);
            #2;
            g++;
        end
    endtask

    // One power-up run; optional disturbance and simultaneous off request.
    task automatic run_on(input bit qv, input logic signed [4:0] ph, input int cv,
                          input int rm, input bit disturb, input bit both);
        int base;
        int d0;
        string tag;
        mode_qvga = qv; phase_adj = ph; comv_adj = 9'(cv); rdy_mode = rm;
        build_exp(qv, ph, cv);
        base = cap_q.size();
        d0   = ndone;
        @(posedge clk); #1;
        pwr_on_req = 1'b1;
        pwr_off_req = both;
        @(posedge clk); #1;
        pwr_on_req = 1'b0;
        pwr_off_req = 1'b0;
        if (disturb) begin
            repeat (30) @(posedge clk);
            #1;
            pwr_on_req = 1'b1; pwr_off_req = 1'b1;
            mode_qvga = ~qv; phase_adj = ~ph; comv_adj = ~comv_adj;
            @(posedge clk); #1;
            pwr_on_req = 1'b0; pwr_off_req = 1'b0;
        end
        wait_done(d0, 5000);
        @(negedge clk);
        chk(cap_q.size() - base == NFR, "R3", "byte count", cap_q.size() - base, NFR);
        chk(ndone == d0 + 1, "R9", "done count", ndone - d0, 1);
        if (cap_q.size() - base == NFR) begin
            for (int i = 0; i < NFR; i++) begin
                if (i == 99)                 tag = "R7";
                else if (i == 101)           tag = "R8";
                else if (i >= 63 && i < 87)  tag = "R6";
                else if (i >= 6 && i < 93)   tag = "R5";
                else                         tag = "R3";
                chk(cap_q[base+i] == exp_f[i], tag, $sformatf("byte %0d", i),
                    cap_q[base+i], exp_f[i]);
                if (i > 0)
                    chk(rise_q[base+i] - hs_q[base+i-1] - 1 == exp_gap[i], "R4",
                        $sformatf("gap before byte %0d", i),
                        rise_q[base+i] - hs_q[base+i-1] - 1, exp_gap[i]);
            end
            chk(done_cyc == hs_q[base+NFR-1] + 1, "R9", "done timing",
                done_cyc, hs_q[base+NFR-1] + 1);
        end
        if (disturb || both) begin
            d0 = ndone;
            base = cap_q.size();
            repeat (34 * CPM + 10) @(posedge clk);
            #2;
            chk(ndone == d0 && cap_q.size() == base, "R11", "dropped request effect",
                ndone - d0 + cap_q.size() - base, 0);
        end
    endtask

    // One power-off run.
    task automatic run_off();
        int d0;
        int f0;
        int rq;
        d0 = ndone;
        f0 = cap_q.size();
        @(posedge clk); #1;
        pwr_off_req = 1'b1;
        rq = cyc;
        @(posedge clk); #1;
        pwr_off_req = 1'b0;
        wait_done(d0, 2000);
        @(negedge clk);
        chk(ndone == d0 + 1, "R10", "off done count", ndone - d0, 1);
        chk(done_cyc == rq + 34 * CPM + 1, "R10", "off done timing",
            done_cyc, rq + 34 * CPM + 1);
        chk(cap_q.size() == f0, "R10", "no bytes during off", cap_q.size() - f0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        pwr_on_req = 1'b0;
        pwr_off_req = 1'b0;
        mode_qvga = 1'b1;
        phase_adj = '0;
        comv_adj = '0;
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        in_reset = 0;
        repeat (5) @(posedge clk);
        #2;
        chk(cap_q.size() == 0 && ndone == 0, "R1", "idle after reset", cap_q.size() + ndone, 0);

        run_off();
        run_on(1'b1, 5'sd5, -3, 0, 1'b0, 1'b0);
        run_on(1'b1, -5'sd1, 200, 1, 1'b0, 1'b0);
        run_on(1'b1, 5'sd0, 125, 2, 1'b0, 1'b1);
        run_on(1'b1, 5'sd2, -256, 1, 1'b0, 1'b0);
        run_on(1'b1, 5'sd9, 255, 0, 1'b0, 1'b0);
        run_on(1'b1, -5'sd16, 0, 2, 1'b0, 1'b0);
        for (int p = -16; p < 16; p++) begin
            run_on(1'b0, 5'(p), p * 15 + 30, (p + 16) % 3, p == 3, 1'b0);
        end
        run_off();

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule